// File: doc/BRIEF.md
# Gigabit Ethernet Receive Clock-Compensation Buffer

This block sits in a Gigabit Ethernet receive path after the 8b/10b decoder. Decoded code groups (an 8-bit value plus a control flag) are written on the recovered clock and come out on the local clock. The two clocks are nominally equal but differ by a small offset. The buffer absorbs that offset by changing the length of the inter-frame gap. It removes a two-group idle set (control K28.5, code 0xBC with the flag set, followed by data D16.2, code 0x50 with the flag clear) when the buffer runs high. It adds such a set when the buffer runs low. Frame contents are never altered.

Insertion and removal always act on the whole K28.5/D16.2 pair, so idle alignment is kept. The block never tries to work its way out of an overflow or an underflow. It raises a sticky full or empty flag, and it stays in that error state until the receiver reset input is pulsed. Status outputs mark the added code groups and pulse once for each removed pair.

Top module: `gbe_elastic_buf`

## Requirements
- R1: Code groups that are not idle pairs (frame bytes) leave the read port unchanged and in write order, whether the write clock is faster or slower than the read clock.
- R2: An insertion always adds exactly two groups on consecutive read cycles: first 0xBC with rd_k=1, then 0x50 with rd_k=0. rd_ins is high on both, and never on one alone.
- R3: An insertion is made only directly after a stored K28.5 followed by a stored D16.2 has been read out, and only while the read-side occupancy is below DEPTH/4. Inside the band between the thresholds, no group is inserted.
- R4: A stored K28.5 and the D16.2 that directly follows it are dropped together on the write side, and only while the write-side occupancy is above 3*DEPTH/4. Two drops are at least four writes apart. Each drop gives exactly one one-cycle rd_del pulse.
- R5: A write arriving when the write-side occupancy equals DEPTH sets full_flag. full_flag stays high with no further writes accepted until rcv_reset.
- R6: When the read side is running and the read-side occupancy is zero, empty_flag is set and rd_valid drops. Both hold until rcv_reset.
- R7: rcv_reset clears both flags, rd_valid, rd_ins and rd_del. After reset, rd_valid stays low until the read-side occupancy reaches 3*DEPTH/8.
- R8: rd_valid is high on every group that is output. rd_ins is low for every group taken from storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rcv_reset | input | 1 | Receiver reset, active high, asynchronous assert; the only way out of the error state |
| wr_clk | input | 1 | Recovered clock |
| wr_valid | input | 1 | A decoded code group is present this cycle |
| wr_k | input | 1 | Control flag of the incoming group |
| wr_data | input | 8 | Value of the incoming group |
| rd_clk | input | 1 | Local system clock |
| rd_valid | output | 1 | Output group valid |
| rd_k | output | 1 | Control flag of the output group |
| rd_data | output | 8 | Value of the output group |
| rd_ins | output | 1 | Output group was added by the block |
| rd_del | output | 1 | One-cycle pulse per removed idle pair |
| full_flag | output | 1 | Overflow seen, sticky (write clock domain) |
| empty_flag | output | 1 | Underflow seen, sticky (read clock domain) |

## Verification
A wrong pointer or occupancy value shows within one frame. Either a frame byte comes out lost, repeated or stale, or a flag rises in a test whose drift should stay inside the threshold band. A wrong threshold or boundary decision shows as inserted or removed pairs where none are expected, or none where the drift requires them, within a few gaps. A wrong insertion state shows in the next read cycle as an unpaired or misordered marked group. A flag that self-clears shows on the cycle after it drops.

// File: rtl/gbe_rm_pkg.sv
package gbe_rm_pkg;
  localparam logic [7:0] COMMA_VAL = 8'hBC;  // K28.5
  localparam logic [7:0] IDLE2_VAL = 8'h50;  // D16.2

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } cgrp_t;

  function automatic logic is_comma_k(input cgrp_t g);
    return g.k && (g.d == COMMA_VAL);
  endfunction

  function automatic logic is_idle_d(input cgrp_t g);
    return !g.k && (g.d == IDLE2_VAL);
  endfunction

  function automatic cgrp_t mk_grp(input logic k, input logic [7:0] d);
    cgrp_t g;
    g.k = k;
    g.d = d;
    return g;
  endfunction
endpackage

// File: rtl/rm_gray_sync.sv
module rm_gray_sync #(
  parameter int W = 4
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dst_bin
);
  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] from_gray(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] src_g, meta_g, sync_g;

  always_ff @(posedge src_clk or posedge src_rst)
    if (src_rst) src_g <= '0;
    else         src_g <= to_gray(src_bin);

  always_ff @(posedge dst_clk or posedge dst_rst)
    if (dst_rst) begin
      meta_g <= '0;
      sync_g <= '0;
    end else begin
      meta_g <= src_g;
      sync_g <= meta_g;
    end

  assign dst_bin = from_gray(sync_g);
endmodule

// File: rtl/rm_wr_side.sv
module rm_wr_side
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  cgrp_t         in_grp,
  input  logic [CW-1:0] rd_cnt,
  output logic          we,
  output logic [AW-1:0] waddr,
  output cgrp_t         wgrp,
  output logic [CW-1:0] wr_cnt,
  output logic          del_tgl,
  output logic          full_flag,
  output logic          drop_evt,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] HI_MARK = CW'(DEPTH * 3 / 4);
  localparam logic [CW-1:0] CAP     = CW'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [CW-1:0] occ;
  logic          hold_v, push, accept;
  cgrp_t         hold_g;
  logic [1:0]    cool;

  always_comb begin
    occ      = wr_cnt - rd_cnt;
    accept   = in_valid && !full_flag;
    drop_evt = accept && hold_v && is_comma_k(hold_g) && is_idle_d(in_grp)
               && (occ > HI_MARK) && (cool == 2'd0);
    push     = accept && hold_v && !drop_evt;
    ovf_evt  = push && (occ >= CAP);
    we       = push && !ovf_evt;
    wgrp     = hold_g;
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      hold_v    <= 1'b0;
      hold_g    <= '0;
      cool      <= '0;
      del_tgl   <= 1'b0;
      full_flag <= 1'b0;
      wr_cnt    <= '0;
      waddr     <= '0;
    end else begin
      if (accept) begin
        hold_v <= !drop_evt;
        hold_g <= in_grp;
      end
      if (drop_evt) begin
        del_tgl <= ~del_tgl;
        cool    <= 2'd3;
      end else if (accept && cool != 2'd0) begin
        cool <= cool - 2'd1;
      end
      if (ovf_evt) full_flag <= 1'b1;
      if (we) begin
        wr_cnt <= wr_cnt + 1'b1;
        waddr  <= (waddr == LAST) ? '0 : waddr + 1'b1;
      end
    end
endmodule

// File: rtl/rm_rd_side.sv
module rm_rd_side
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] wr_cnt,
  input  cgrp_t         rgrp,
  input  logic          del_tgl_s,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] rd_cnt,
  output cgrp_t         out_grp,
  output logic          out_valid,
  output logic          out_ins,
  output logic          out_del,
  output logic          empty_flag,
  output logic          pair_done
);
  localparam logic [CW-1:0] LOW_MARK  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] START_LVL = CW'(DEPTH * 3 / 8);
  localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);

  typedef enum logic [1:0] {RS_FILL, RS_RUN, RS_INS_D, RS_ERR} rs_t;
  rs_t           st;
  logic [CW-1:0] occ;
  logic          prev_k, del_q, stored_now;

  always_comb begin
    occ        = wr_cnt - rd_cnt;
    stored_now = out_valid && !out_ins;
    pair_done  = stored_now && prev_k && is_idle_d(out_grp);
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st         <= RS_FILL;
      out_grp    <= '0;
      out_valid  <= 1'b0;
      out_ins    <= 1'b0;
      out_del    <= 1'b0;
      del_q      <= 1'b0;
      prev_k     <= 1'b0;
      empty_flag <= 1'b0;
      rd_cnt     <= '0;
      raddr      <= '0;
    end else begin
      del_q   <= del_tgl_s;
      out_del <= del_tgl_s ^ del_q;
      unique case (st)
        RS_FILL: if (occ >= START_LVL) st <= RS_RUN;
        RS_RUN: begin
          if (pair_done && occ < LOW_MARK) begin
            out_grp <= mk_grp(1'b1, COMMA_VAL);
            out_ins <= 1'b1;
            prev_k  <= 1'b0;
            st      <= RS_INS_D;
          end else if (occ == '0) begin
            out_valid  <= 1'b0;
            out_ins    <= 1'b0;
            empty_flag <= 1'b1;
            st         <= RS_ERR;
          end else begin
            prev_k    <= stored_now && is_comma_k(out_grp);
            out_grp   <= rgrp;
            out_valid <= 1'b1;
            out_ins   <= 1'b0;
            rd_cnt    <= rd_cnt + 1'b1;
            raddr     <= (raddr == LAST) ? '0 : raddr + 1'b1;
          end
        end
        RS_INS_D: begin
          out_grp <= mk_grp(1'b0, IDLE2_VAL);
          prev_k  <= 1'b0;
          st      <= RS_RUN;
        end
        default: st <= RS_ERR;
      endcase
    end
endmodule

// File: rtl/gbe_elastic_buf.sv
module gbe_elastic_buf
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic       rcv_reset,
  input  logic       wr_clk,
  input  logic       wr_valid,
  input  logic       wr_k,
  input  logic [7:0] wr_data,
  input  logic       rd_clk,
  output logic       rd_valid,
  output logic       rd_k,
  output logic [7:0] rd_data,
  output logic       rd_ins,
  output logic       rd_del,
  output logic       full_flag,
  output logic       empty_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0]    wr_rs, rd_rs;
  logic          wr_rst, rd_rst;
  logic          we, del_tgl, del_tgl_s;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wr_cnt, rd_cnt, wr_cnt_s, rd_cnt_s;
  cgrp_t         wgrp, rgrp, out_grp;
  cgrp_t         store [DEPTH];
  logic          evt_drop, evt_overflow, evt_pair_done;

  always_ff @(posedge wr_clk or posedge rcv_reset)
    if (rcv_reset) wr_rs <= 2'b11;
    else           wr_rs <= {wr_rs[0], 1'b0};

  always_ff @(posedge rd_clk or posedge rcv_reset)
    if (rcv_reset) rd_rs <= 2'b11;
    else           rd_rs <= {rd_rs[0], 1'b0};

  assign wr_rst = wr_rs[1];
  assign rd_rst = rd_rs[1];

  rm_wr_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid), .in_grp(mk_grp(wr_k, wr_data)),
    .rd_cnt(rd_cnt_s), .we(we), .waddr(waddr), .wgrp(wgrp), .wr_cnt(wr_cnt),
    .del_tgl(del_tgl), .full_flag(full_flag), .drop_evt(evt_drop), .ovf_evt(evt_overflow)
  );

  always_ff @(posedge wr_clk)
    if (we) store[waddr] <= wgrp;

  assign rgrp = store[raddr];

  rm_gray_sync #(.W(CW)) u_wsync (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_cnt),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(wr_cnt_s)
  );

  rm_gray_sync #(.W(CW)) u_rsync (
    .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_cnt),
    .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rd_cnt_s)
  );

  rm_gray_sync #(.W(1)) u_dsync (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(del_tgl),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(del_tgl_s)
  );

  rm_rd_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .wr_cnt(wr_cnt_s), .rgrp(rgrp), .del_tgl_s(del_tgl_s),
    .raddr(raddr), .rd_cnt(rd_cnt), .out_grp(out_grp), .out_valid(rd_valid),
    .out_ins(rd_ins), .out_del(rd_del), .empty_flag(empty_flag), .pair_done(evt_pair_done)
  );

  assign rd_k    = out_grp.k;
  assign rd_data = out_grp.d;
endmodule

// File: rtl/rm_checker.sv
module rm_checker (
  input logic       rcv_reset,
  input logic       wr_clk,
  input logic       rd_clk,
  input logic       rd_valid,
  input logic       rd_k,
  input logic [7:0] rd_data,
  input logic       rd_ins,
  input logic       rd_del,
  input logic       full_flag,
  input logic       empty_flag,
  input logic       evt_drop,
  input logic       evt_pair_done
);
  AST_INS_STARTS_WITH_COMMA: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    $rose(rd_ins) |-> rd_k && rd_data == 8'hBC);  // R2
  AST_INS_COMMA_THEN_IDLE: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    rd_ins && rd_k |=> rd_ins && !rd_k && rd_data == 8'h50);  // R2
  AST_INS_AFTER_PAIR: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    rd_ins && rd_k && !$past(rd_ins) |-> $past(evt_pair_done));  // R3
  AST_INS_IS_VALID: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    rd_ins |-> rd_valid);  // R8
  AST_DEL_ONE_CYCLE: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    rd_del |=> !rd_del);  // R4
  AST_DROP_SPACED: assert property (@(posedge wr_clk) disable iff (rcv_reset)
    evt_drop |=> !evt_drop);  // R4
  AST_FULL_STICKY: assert property (@(posedge wr_clk) disable iff (rcv_reset)
    full_flag |=> full_flag);  // R5
  AST_EMPTY_STICKY: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    empty_flag |=> empty_flag);  // R6
  AST_EMPTY_SILENT: assert property (@(posedge rd_clk) disable iff (rcv_reset)
    empty_flag |-> !rd_valid);  // R6
endmodule

bind gbe_elastic_buf rm_checker u_chk (
  .rcv_reset(rcv_reset), .wr_clk(wr_clk), .rd_clk(rd_clk), .rd_valid(rd_valid),
  .rd_k(rd_k), .rd_data(rd_data), .rd_ins(rd_ins), .rd_del(rd_del),
  .full_flag(full_flag), .empty_flag(empty_flag), .evt_drop(evt_drop),
  .evt_pair_done(evt_pair_done)
);

// File: tb/sim_gbe_elastic_buf.sv
module sim_gbe_elastic_buf;
  timeunit 1ns;
  timeprecision 1fs;

  logic       rcv_reset = 1'b1, wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_valid = 1'b0, wr_k = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_valid, rd_k, rd_ins, rd_del, full_flag, empty_flag;
  logic [7:0] rd_data;
  real        wr_half = 2.5;
  int         n_chk = 0, n_err = 0, tx_seq = 0;

  gbe_elastic_buf u0 (
    .rcv_reset(rcv_reset), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_k(wr_k),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_valid(rd_valid), .rd_k(rd_k),
    .rd_data(rd_data), .rd_ins(rd_ins), .rd_del(rd_del), .full_flag(full_flag),
    .empty_flag(empty_flag)
  );

  initial forever #2.5 rd_clk = ~rd_clk;  // 200 MHz
  initial forever #(wr_half) wr_clk = ~wr_clk;

  // read-port monitor
  logic       mon_en = 1'b0, mon_clr = 1'b0;
  int         rx_bytes, bad_bytes, ins_pairs, bad_ins, del_cnt;
  logic [7:0] exp_b, p1_d, p2_d;
  logic       p1_k, p1_i, p2_k, p2_i;

  always @(negedge rd_clk) begin
    if (mon_clr) begin
      rx_bytes = 0; bad_bytes = 0; ins_pairs = 0; bad_ins = 0; del_cnt = 0;
      exp_b = 8'h00; p1_k = 0; p1_i = 0; p2_k = 0; p2_i = 0; p1_d = 0; p2_d = 0;
    end else if (mon_en) begin
      if (rd_del) del_cnt++;
      if (rd_valid) begin
        if (rd_ins) begin
          if (rd_k) begin
            ins_pairs++;
            if (!(p2_k && p2_d == 8'hBC && !p2_i && !p1_k && p1_d == 8'h50 && !p1_i)) bad_ins++;
          end
        end else if (!rd_k && !(p1_k && p1_d == 8'hBC)) begin
          rx_bytes++;
          if (rd_data !== exp_b) bad_bytes++;
          exp_b++;
        end
        p2_k = p1_k; p2_d = p1_d; p2_i = p1_i;
        p1_k = rd_k; p1_d = rd_data; p1_i = rd_ins;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input bit k, input logic [7:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_k     = k;
    wr_data  = d;
  endtask

  task automatic put_idle();
    put(1'b1, 8'hBC);
    put(1'b0, 8'h50);
  endtask

  task automatic do_reset();
    wr_valid  = 1'b0;
    rcv_reset = 1'b1;
    repeat (4) @(negedge rd_clk);
    rcv_reset = 1'b0;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(full_flag == 0, "R7", "full_flag after reset", full_flag, 0);
    check(empty_flag == 0, "R7", "empty_flag after reset", empty_flag, 0);
    check(rd_valid == 0, "R7", "rd_valid after reset", rd_valid, 0);
    check(rd_ins == 0, "R7", "rd_ins after reset", rd_ins, 0);
    check(rd_del == 0, "R7", "rd_del after reset", rd_del, 0);
    for (int i = 0; i < 6; i++) put(1'b0, 8'(i));
    wr_valid = 1'b0;
    repeat (12) @(negedge rd_clk);
    check(rd_valid == 0, "R7", "rd_valid below start level", rd_valid, 0);
  endtask

  task automatic t_drift(input string tag, input real half, input bit want_ins, input bit want_del);
    wr_half = half;
    do_reset();
    mon_clr = 1'b1;
    @(negedge rd_clk);
    mon_clr = 1'b0;
    mon_en  = 1'b1;
    tx_seq  = 0;
    for (int f = 0; f < 30; f++) begin
      for (int i = 0; i < 48; i++) begin
        put(1'b0, 8'(tx_seq));
        tx_seq++;
      end
      for (int g = 0; g < 8; g++) put_idle();
    end
    for (int g = 0; g < 16; g++) put_idle();
    wr_valid = 1'b0;
    mon_en   = 1'b0;
    check(bad_bytes == 0, "R1", {tag, " frame byte mismatches"}, bad_bytes, 0);
    check(rx_bytes == tx_seq, "R1", {tag, " frame bytes delivered"}, rx_bytes, tx_seq);
    check(bad_ins == 0, "R3", {tag, " insertions off a stored pair"}, bad_ins, 0);
    check(full_flag == 0, "R5", {tag, " full_flag"}, full_flag, 0);
    check(empty_flag == 0, "R6", {tag, " empty_flag"}, empty_flag, 0);
    if (want_ins) check(ins_pairs > 0, "R2", {tag, " inserted pairs"}, ins_pairs, 1);
    else          check(ins_pairs == 0, "R3", {tag, " inserted pairs in band"}, ins_pairs, 0);
    if (want_del) check(del_cnt > 0, "R4", {tag, " removed pairs"}, del_cnt, 1);
    else          check(del_cnt == 0, "R4", {tag, " removed pairs in band"}, del_cnt, 0);
  endtask

  task automatic t_full();
    wr_half = 1.25;
    do_reset();
    for (int i = 0; i < 120; i++) put(1'b0, 8'(i));
    wr_valid = 1'b0;
    check(full_flag == 1, "R5", "full_flag after overflow", full_flag, 1);
    @(negedge wr_clk);
    @(negedge wr_clk);
    check(full_flag == 1, "R5", "full_flag two cycles later", full_flag, 1);
    repeat (100) @(negedge wr_clk);
    check(full_flag == 1, "R5", "full_flag without reset", full_flag, 1);
    do_reset();
    check(full_flag == 0, "R7", "full_flag cleared by reset", full_flag, 0);
  endtask

  task automatic t_empty();
    wr_half = 2.5;
    do_reset();
    for (int g = 0; g < 20; g++) put_idle();
    wr_valid = 1'b0;
    repeat (100) @(negedge rd_clk);
    check(empty_flag == 1, "R6", "empty_flag after underflow", empty_flag, 1);
    check(rd_valid == 0, "R6", "rd_valid in empty state", rd_valid, 0);
    repeat (2) @(negedge rd_clk);
    check(empty_flag == 1, "R6", "empty_flag two cycles later", empty_flag, 1);
    repeat (50) @(negedge rd_clk);
    check(empty_flag == 1 && rd_valid == 0, "R6", "empty state without reset", empty_flag, 1);
    do_reset();
    check(empty_flag == 0, "R7", "empty_flag cleared by reset", empty_flag, 0);
  endtask

  initial begin
    repeat (180000) @(posedge rd_clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_drift("ppm_fast_wr", 2.49975, 1'b0, 1'b0);
    t_drift("ppm_slow_wr", 2.50025, 1'b0, 1'b0);
    t_drift("slow_wr", 2.55, 1'b1, 1'b0);
    t_drift("fast_wr", 2.45, 1'b0, 1'b1);
    t_full();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule